// File: doc/BRIEF.md
# Microcontroller Interrupt Aggregation Controller

This block collects the interrupt requests of a small 8-bit microcontroller and drives two lines toward the CPU: an interrupt request and a wake-up request. It watches three sources itself. The first is an external pin whose active edge is selectable. The second is an 8-bit timer count that wraps from its maximum to zero. The third is a six-pin port with a change detector, where each pin can be enabled separately and can be marked as analog. A further vector of peripheral flag/enable pairs is combined and gated by a peripheral group enable.

Each source has a sticky flag and an enable bit. Software reaches them through a small register interface. A flag that is enabled raises wake-up whether or not the global enable is set. The CPU interrupt line also needs the global enable. When a hardware event and a software write to the same flag land in one cycle, the event wins.

Top module: `irq_aggregator`

## Requirements
- R1: After the synchronous active-high reset, every register reads 0x00 and both `cpu_irq` and `wake` are low.
- R2: When edge select (address 1, bit 0) is 1, a rising edge on `ext_pin` sets the external flag (address 0, bit 1). A falling edge does not set it.
- R3: When edge select is 0, a falling edge on `ext_pin` sets the external flag. A rising edge does not set it.
- R4: A flag stays set after its cause goes away. It clears only when software writes 0 to that bit at address 0.
- R5: The timer flag (address 0, bit 2) is set when `tmr_count` goes from 0xFF to 0x00 on consecutive cycles. Other transitions, such as 0x7F to 0x80 or 0x00 to 0x01, do not set it.
- R6: A level change on port pin i sets the port flag (address 0, bit 0) only if bit i of the change mask (address 2) is 1.
- R7: A pin marked analog (address 3, bit i = 1) is treated as a constant 0 and never sets the port flag.
- R8: `wake` is the OR of every flag ANDed with its own enable, whatever the global enable (address 0, bit 7) holds. The enables are port bit 3, external bit 4 and timer bit 5. The peripheral term is the OR of `per_flag & per_en`, and it counts only when the group enable (address 0, bit 6) is 1.
- R9: `cpu_irq` is high exactly when `wake` is high and the global enable is 1.
- R10: If a hardware event sets a flag in the same cycle that software writes 0 to it, the flag stays set.
- R11: Both outputs fall in the cycle right after the write that clears the last enabled flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control/flags, 1 edge select, 2 change mask, 3 analog mask) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | NPINS | Port pins watched for change, asynchronous |
| tmr_count | input | TMR_W | Current timer count |
| per_flag | input | NPER | Peripheral request flags |
| per_en | input | NPER | Peripheral enables, one per flag |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | Wake-up request |

## Verification
The assertions assume a few things about the inputs. `tmr_count` changes at most once per cycle. The pins are at their idle low level when reset is released. No change in pin configuration is timed to coincide with a pin edge. The stimulus holds pins low through reset and changes the edge select and the masks only while the pins are quiet. It also leaves several cycles between a pin change and the next check, so the synchronizer delay never decides a result. It never requires a port event that coincides with a port read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_EDGE   = 2'd1,
    A_CHMASK = 2'd2,
    A_ANALOG = 2'd3
  } reg_addr_e;

  localparam int B_PORT_F = 0;
  localparam int B_EXT_F  = 1;
  localparam int B_TMR_F  = 2;
  localparam int B_PORT_E = 3;
  localparam int B_EXT_E  = 4;
  localparam int B_TMR_E  = 5;
  localparam int B_GRP_E  = 6;
  localparam int B_GLB_E  = 7;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_pin_edge.sv
module irq_pin_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic rise_sel,
  output logic hit
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= pin_s;
  end

  assign hit = rise_sel ? (pin_s & ~prev) : (~pin_s & prev);

  p_edge_dir_r2: assert property (@(posedge clk) disable iff (rst)
    (hit && rise_sel) |-> pin_s);
  p_edge_dir_r3: assert property (@(posedge clk) disable iff (rst)
    (hit && !rise_sel) |-> !pin_s);
endmodule

// File: rtl/irq_port_change.sv
module irq_port_change #(
  parameter int NPINS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pins_s,
  input  logic [NPINS-1:0] chg_mask,
  input  logic [NPINS-1:0] analog,
  output logic             hit
);
  logic [NPINS-1:0] prev;
  logic [NPINS-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= pins_s;
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      diff[i] = (pins_s[i] ^ prev[i]) & chg_mask[i] & ~analog[i];
    end
  end

  assign hit = |diff;

  // an event needs at least one pin that is both enabled and digital
  p_needs_digital_pin_r7: assert property (@(posedge clk) disable iff (rst)
    hit |-> (|(chg_mask & ~analog)));
  p_needs_change_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> (pins_s != prev));
endmodule

// File: rtl/irq_tmr_wrap.sv
module irq_tmr_wrap #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMR_W-1:0] count,
  output logic             hit
);
  logic [TMR_W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= count;
  end

  assign hit = (prev == {TMR_W{1'b1}}) && (count == '0);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int NPINS  = 6,
  parameter int TMR_W  = 8,
  parameter int NPER   = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ext_pin,
  input  logic [NPINS-1:0] port_pins,
  input  logic [TMR_W-1:0] tmr_count,
  input  logic [NPER-1:0]  per_flag,
  input  logic [NPER-1:0]  per_en,
  output logic             cpu_irq,
  output logic             wake
);
  localparam int PAD = REG_W - NPINS;

  logic             ext_s, ext_hit, port_hit, tmr_hit;
  logic [NPINS-1:0] port_s;
  logic             f_port, f_ext, f_tmr;
  logic             e_port, e_ext, e_tmr, e_grp, e_glb;
  logic             edge_rise;
  logic [NPINS-1:0] chg_mask, analog;
  logic             wr_ctrl, per_term;

  irq_sync #(.W(1), .STAGES(STAGES)) u_ext_sync (
    .clk(clk), .rst(rst), .d(ext_pin), .q(ext_s));
  irq_sync #(.W(NPINS), .STAGES(STAGES)) u_port_sync (
    .clk(clk), .rst(rst), .d(port_pins), .q(port_s));

  irq_pin_edge u_edge (
    .clk(clk), .rst(rst), .pin_s(ext_s), .rise_sel(edge_rise), .hit(ext_hit));
  irq_port_change #(.NPINS(NPINS)) u_chg (
    .clk(clk), .rst(rst), .pins_s(port_s), .chg_mask(chg_mask),
    .analog(analog), .hit(port_hit));
  irq_tmr_wrap #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .count(tmr_count), .hit(tmr_hit));

  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_port <= 1'b0; f_ext <= 1'b0; f_tmr <= 1'b0;
      e_port <= 1'b0; e_ext <= 1'b0; e_tmr <= 1'b0;
      e_grp  <= 1'b0; e_glb <= 1'b0;
      edge_rise <= 1'b0;
      chg_mask  <= '0;
      analog    <= '0;
    end else begin
      if (wr_ctrl) begin
        f_port <= reg_wdata[B_PORT_F];
        f_ext  <= reg_wdata[B_EXT_F];
        f_tmr  <= reg_wdata[B_TMR_F];
        e_port <= reg_wdata[B_PORT_E];
        e_ext  <= reg_wdata[B_EXT_E];
        e_tmr  <= reg_wdata[B_TMR_E];
        e_grp  <= reg_wdata[B_GRP_E];
        e_glb  <= reg_wdata[B_GLB_E];
      end
      if (reg_we && reg_addr == A_EDGE)   edge_rise <= reg_wdata[0];
      if (reg_we && reg_addr == A_CHMASK) chg_mask  <= reg_wdata[NPINS-1:0];
      if (reg_we && reg_addr == A_ANALOG) analog    <= reg_wdata[NPINS-1:0];
      // hardware events override a same-cycle software write
      if (port_hit) f_port <= 1'b1;
      if (ext_hit)  f_ext  <= 1'b1;
      if (tmr_hit)  f_tmr  <= 1'b1;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(reg_addr))
      A_CTRL:   reg_rdata = {e_glb, e_grp, e_tmr, e_ext, e_port, f_tmr, f_ext, f_port};
      A_EDGE:   reg_rdata = {7'd0, edge_rise};
      A_CHMASK: reg_rdata = {{PAD{1'b0}}, chg_mask};
      default:  reg_rdata = {{PAD{1'b0}}, analog};
    endcase
  end

  assign per_term = (|(per_flag & per_en)) & e_grp;
  assign wake     = (f_port & e_port) | (f_ext & e_ext) | (f_tmr & e_tmr) | per_term;
  assign cpu_irq  = wake & e_glb;

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (f_ext && !wr_ctrl) |=> f_ext);
  p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (tmr_hit && wr_ctrl) |=> f_tmr);
  p_timer_sets_r5: assert property (@(posedge clk) disable iff (rst)
    tmr_hit |=> f_tmr);
  p_port_sets_r6: assert property (@(posedge clk) disable iff (rst)
    port_hit |=> f_port);
  p_wake_ignores_glb_r8: assert property (@(posedge clk) disable iff (rst)
    (f_ext && e_ext) |-> wake);
  p_irq_needs_glb_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_irq |-> (wake && e_glb));
endmodule

// File: tb/irq_aggregator_tb_top.sv
module irq_aggregator_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       ext_pin = 1'b0;
  logic [5:0] port_pins = 6'd0;
  logic [7:0] tmr_count = 8'd0;
  logic [7:0] per_flag = 8'd0;
  logic [7:0] per_en = 8'd0;
  logic       cpu_irq, wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    int         kind;   // 0: read register at reg_addr, 1: {cpu_irq, wake}
    logic [7:0] exp;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  irq_aggregator dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
    .port_pins(port_pins), .tmr_count(tmr_count), .per_flag(per_flag),
    .per_en(per_en), .cpu_irq(cpu_irq), .wake(wake));

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = q.pop_front();
        got = (it.kind == 0) ? reg_rdata : {6'd0, cpu_irq, wake};
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] e);
    item_t it;
    reg_addr = a;
    it.req = req; it.kind = 0; it.exp = e;
    q.push_back(it);
    wait (q.size() == 0);
    #1;
    reg_addr = 2'd0;
  endtask

  task automatic expect_out(input string req, input logic irq_e, input logic wake_e);
    item_t it;
    it.req = req; it.kind = 1; it.exp = {6'd0, irq_e, wake_e};
    q.push_back(it);
    wait (q.size() == 0);
    #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    expect_reg("R1", 2'd0, 8'h00);
    expect_reg("R1", 2'd2, 8'h00);
    expect_out("R1", 1'b0, 1'b0);

    // R2 rising edge select
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h10);
    ext_pin = 1'b1; cyc(6);
    expect_reg("R2", 2'd0, 8'h12);
    expect_out("R8", 1'b0, 1'b1);
    ext_pin = 1'b0; cyc(6);
    expect_reg("R4", 2'd0, 8'h12);
    wr(2'd0, 8'h92);
    expect_out("R9", 1'b1, 1'b1);
    wr(2'd0, 8'h90);
    expect_out("R11", 1'b0, 1'b0);

    // R3 falling edge select
    wr(2'd1, 8'h00);
    ext_pin = 1'b1; cyc(6);
    expect_reg("R3", 2'd0, 8'h90);
    ext_pin = 1'b0; cyc(6);
    expect_reg("R3", 2'd0, 8'h92);
    wr(2'd0, 8'h00);

    // R5 timer wrap
    tmr_count = 8'h7F; cyc(1);
    tmr_count = 8'h80; cyc(1);
    tmr_count = 8'h00; cyc(1);
    tmr_count = 8'h01; cyc(2);
    expect_reg("R5", 2'd0, 8'h00);
    tmr_count = 8'hFF; cyc(1);
    tmr_count = 8'h00; cyc(2);
    expect_reg("R5", 2'd0, 8'h04);

    // R10 set beats a same-cycle clear
    tmr_count = 8'hFF; cyc(1);
    tmr_count = 8'h00;
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00;
    cyc(1);
    reg_we = 1'b0;
    expect_reg("R10", 2'd0, 8'h04);
    wr(2'd0, 8'h00);
    expect_reg("R4", 2'd0, 8'h00);

    // R6 port change mask
    wr(2'd2, 8'h01);
    port_pins = 6'b000010; cyc(6);
    expect_reg("R6", 2'd0, 8'h00);
    port_pins = 6'b000011; cyc(6);
    expect_reg("R6", 2'd0, 8'h01);
    wr(2'd0, 8'h00);

    // R7 analog pin is quiet
    wr(2'd3, 8'h01);
    port_pins = 6'b000010; cyc(6);
    port_pins = 6'b000011; cyc(6);
    expect_reg("R7", 2'd0, 8'h00);

    // R8 peripheral group gating
    per_flag = 8'h04; per_en = 8'h04;
    wr(2'd0, 8'h80);
    expect_out("R8", 1'b0, 1'b0);
    wr(2'd0, 8'hC0);
    expect_out("R9", 1'b1, 1'b1);
    per_en = 8'h00; cyc(1);
    expect_out("R8", 1'b0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule